// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point numbers. Each number has a sign bit, an 8-bit biased exponent and a 23-bit fraction. The arithmetic runs through five fixed stages:

- **Unpack and order:** the hidden bit is restored, and the operand with the larger magnitude is routed to the main path.
- **Align:** the smaller mantissa is shifted right, and everything shifted out is gathered into guard, round and sticky bits.
- **Add/subtract:** an integer add or subtract of the two mantissas.
- **Normalise:** a leading-one search and a left or right shift.
- **Round:** round to nearest, with ties going to even.

A parameter sets how many register levels follow each stage. The total latency can therefore be matched to the clock rate of the surrounding datapath. The total is anywhere from 0 upward and typically between 6 and 18.

Operations enter as a stream. Whenever `in_valid` is high, one operand pair is accepted, with no limit on consecutive cycles. The result appears on `out_res` with `out_valid` exactly `LATENCY` cycles later, where `LATENCY` is the sum of the five stage depths. There is no back-pressure: the block has no ready signal, and the consumer must take each result in the cycle its valid is high. Input encodings with a zero exponent field are treated as zero. Inputs whose exponent field is all ones are not given any special meaning.

Top module: `fpadd_pipe`

## Requirements
- R1: For two normal operands of the same effective sign, `out_res` is their sum rounded to nearest-even, packed as {sign[31], biased exponent[30:23], fraction[22:0]}. The result carries the common sign.
- R2: When `in_sub` is 1 the block computes `in_a - in_b` by inverting the sign of `in_b`. When it is 0 it computes `in_a + in_b`.
- R3: Operands whose exponents differ by any amount are aligned correctly. For a difference of 26 or more, the smaller operand affects the result only through rounding.
- R4: Subtraction of nearly equal values is normalised so that the leading one lands in the hidden position. Any exactly zero result is returned as +0 (0x00000000).
- R5: Rounding is to nearest. An exact halfway case rounds to the value with an even (zero) fraction LSB.
- R6: If rounding carries out of the mantissa, the result is renormalised: the fraction becomes zero and the exponent goes up by one.
- R7: A rounded result whose biased exponent reaches 255 gives an infinity with the result's sign (0x7F800000 or 0xFF800000).
- R8: An input with exponent field 0 is taken as zero. A nonzero result whose exponent before rounding is below 1 is returned as a zero carrying the result's sign.
- R9: `out_valid` equals `in_valid` delayed by exactly LATENCY = ST_UNPACK + ST_ALIGN + ST_ADDSUB + ST_NORM + ST_ROUND cycles. A new pair is accepted every cycle, and idle cycles leave gaps at the output.
- R10: While `rst_n` is low, `out_valid` is 0, including when `in_valid` is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Operand pair present this cycle |
| in_sub | input | 1 | 1 = subtract `in_b` from `in_a`, 0 = add |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 32 | Rounded sum or difference |

## Verification
Operand pairs are drawn in several families:

- **Exponents within two of each other, added and subtracted:** these exercise heavy cancellation and the large left shift of normalisation.
- **Exponents 3 to 35 apart:** these stress the alignment shifter and the sticky collapse. The far end of this range shows whether a distant operand leaks into the result other than through rounding.
- **Full-range pairs:** these cover sign handling on subtraction.
- **Operands packed near the top or bottom of the exponent range:** these separate overflow to infinity from flush to zero.

Directed pairs pin the halfway cases, the carry out of rounding, exact cancellation to +0 and zero-exponent inputs. Two instances with different stage depths share one stream with random idle gaps, which shows that the latency follows the stage parameters and that idle slots stay in place.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  localparam int WORD_W = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int MANT_W = FRAC_W + 1;         // with hidden bit
  localparam int EXT_W  = MANT_W + 3;         // plus guard, round, sticky
  localparam int SUM_W  = EXT_W + 1;          // plus carry
  localparam int NEXP_W = EXP_W + 2;          // signed exponent headroom
  localparam int ALN_W  = EXT_W + MANT_W;     // alignment shifter width
  localparam int SH_W   = 5;                  // alignment shift amount bits
  localparam int LZ_W   = 5;                  // leading-zero count bits
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  typedef struct packed {
    logic              sign;
    logic              eff_sub;
    logic [EXP_W-1:0]  exp_big;
    logic [EXP_W-1:0]  diff;
    logic [MANT_W-1:0] m_big;
    logic [MANT_W-1:0] m_small;
  } unpk_t;

  typedef struct packed {
    logic              sign;
    logic              eff_sub;
    logic [EXP_W-1:0]  exp_big;
    logic [EXT_W-1:0]  m_big;
    logic [EXT_W-1:0]  m_small;
  } algn_t;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp_big;
    logic [SUM_W-1:0]  sum;
  } sum_t;

  typedef struct packed {
    logic                     sign;
    logic                     zero;
    logic                     tiny;
    logic signed [NEXP_W-1:0] exp;
    logic [EXT_W-1:0]         mant;
  } norm_t;

  function automatic logic [LZ_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
    logic [LZ_W-1:0] n;
    n = LZ_W'(EXT_W);
    for (int i = 0; i < EXT_W; i++) begin
      if (v[i]) n = LZ_W'(EXT_W - 1 - i);
    end
    return n;
  endfunction

endpackage

// File: rtl/fpadd_slice.sv
module fpadd_slice #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign vld_o = vld_i;
      assign dat_o = dat_i;
    end else begin : g_regs
      logic [DEPTH-1:0] v_q;
      logic [W-1:0]     d_q [DEPTH];

      for (genvar k = 0; k < DEPTH; k++) begin : g_lvl
        logic         v_in;
        logic [W-1:0] d_in;
        if (k == 0) begin : g_first
          assign v_in = vld_i;
          assign d_in = dat_i;
        end else begin : g_next
          assign v_in = v_q[k-1];
          assign d_in = d_q[k-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) v_q[k] <= 1'b0;
          else        v_q[k] <= v_in;
        end

        // data is loaded only for live slots; bubbles do not toggle it
        always_ff @(posedge clk) begin
          if (v_in) d_q[k] <= d_in;
        end
      end

      assign vld_o = v_q[DEPTH-1];
      assign dat_o = d_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              sub_i,
  output unpk_t             res_o
);

  logic [EXP_W-1:0]  ea, eb;
  logic [MANT_W-1:0] ma, mb;
  logic              sa, sb, a_big;

  always_comb begin
    ea = op_a[WORD_W-2 -: EXP_W];
    eb = op_b[WORD_W-2 -: EXP_W];
    // zero exponent field: treated as zero, hidden bit not restored
    ma = (ea == '0) ? '0 : {1'b1, op_a[FRAC_W-1:0]};
    mb = (eb == '0) ? '0 : {1'b1, op_b[FRAC_W-1:0]};
    sa = op_a[WORD_W-1];
    sb = op_b[WORD_W-1] ^ sub_i;
    a_big = {ea, ma} >= {eb, mb};

    res_o.sign    = a_big ? sa : sb;
    res_o.eff_sub = sa ^ sb;
    res_o.exp_big = a_big ? ea : eb;
    res_o.m_big   = a_big ? ma : mb;
    res_o.m_small = a_big ? mb : ma;
    res_o.diff    = a_big ? (ea - eb) : (eb - ea);
  end

  AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !res_o.eff_sub && op_a[WORD_W-2 -: EXP_W] != '0) |-> (res_o.sign == op_a[WORD_W-1])); // R1

  AST_ZERO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !res_o.m_big[MANT_W-1]) |-> (res_o.m_small == '0)); // R8

endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
  import fpadd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vld_i,
  input  sum_t  sum_i,
  output norm_t nrm_o
);

  logic [LZ_W-1:0]          lz;
  logic signed [NEXP_W-1:0] e_base, e_n;

  always_comb begin
    e_base = signed'({2'b00, sum_i.exp_big});
    lz     = lead_zeros(sum_i.sum[EXT_W-1:0]);
    if (sum_i.sum[SUM_W-1]) begin
      // carry out of the add: shift right one, fold the lost bit into sticky
      nrm_o.mant = {sum_i.sum[SUM_W-1:2], sum_i.sum[1] | sum_i.sum[0]};
      e_n        = e_base + NEXP_W'(1);
    end else begin
      nrm_o.mant = sum_i.sum[EXT_W-1:0] << lz;
      e_n        = e_base - signed'({{(NEXP_W-LZ_W){1'b0}}, lz});
    end
    nrm_o.exp  = e_n;
    nrm_o.sign = sum_i.sign;
    nrm_o.zero = (sum_i.sum == '0);
    nrm_o.tiny = (sum_i.sum != '0) && (e_n <= NEXP_W'(0));
  end

  AST_NORM_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !nrm_o.zero) |-> nrm_o.mant[EXT_W-1]); // R4

endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  norm_t             nrm_i,
  output logic [WORD_W-1:0] res_o
);

  logic                     lsb, grd, rest, up;
  logic [MANT_W:0]          m_r;
  logic [FRAC_W-1:0]        frac;
  logic signed [NEXP_W-1:0] e_r;

  always_comb begin
    lsb  = nrm_i.mant[3];
    grd  = nrm_i.mant[2];
    rest = nrm_i.mant[1] | nrm_i.mant[0];
    up   = grd & (rest | lsb);
    m_r  = {1'b0, nrm_i.mant[EXT_W-1:3]} + (MANT_W+1)'(up);
    if (m_r[MANT_W]) begin
      frac = m_r[FRAC_W:1];
      e_r  = nrm_i.exp + NEXP_W'(1);
    end else begin
      frac = m_r[FRAC_W-1:0];
      e_r  = nrm_i.exp;
    end

    if (nrm_i.zero)
      res_o = '0;
    else if (nrm_i.tiny)
      res_o = {nrm_i.sign, {(WORD_W-1){1'b0}}};
    else if (e_r >= signed'({2'b00, EXP_MAX}))
      res_o = {nrm_i.sign, EXP_MAX, {FRAC_W{1'b0}}};
    else
      res_o = {nrm_i.sign, e_r[EXP_W-1:0], frac};
  end

  AST_INF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && res_o[WORD_W-2 -: EXP_W] == EXP_MAX) |-> (res_o[FRAC_W-1:0] == '0)); // R7

  AST_ZERO_PLUS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && nrm_i.zero) |-> (res_o == '0)); // R4

endmodule

// File: rtl/fpadd_pipe.sv
module fpadd_pipe
  import fpadd_pkg::*;
#(
  parameter int unsigned ST_UNPACK = 1,
  parameter int unsigned ST_ALIGN  = 1,
  parameter int unsigned ST_ADDSUB = 1,
  parameter int unsigned ST_NORM   = 1,
  parameter int unsigned ST_ROUND  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sub,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_res
);

  localparam int unsigned LATENCY = ST_UNPACK + ST_ALIGN + ST_ADDSUB + ST_NORM + ST_ROUND;
  localparam int unsigned CNT_W   = $clog2(LATENCY + 2) + 1;

  unpk_t             up_c, up_q;
  algn_t             al_c, al_q;
  sum_t              sm_c, sm_q;
  norm_t             nm_c, nm_q;
  logic [WORD_W-1:0] rd_c;
  logic              up_v, al_v, sm_v, nm_v;

  // stage 1: unpack, order by magnitude
  fpadd_unpack u_unpack (
    .clk, .rst_n, .vld_i(in_valid), .op_a(in_a), .op_b(in_b), .sub_i(in_sub), .res_o(up_c)
  );
  fpadd_slice #(.W($bits(unpk_t)), .DEPTH(ST_UNPACK)) u_sl_unpack (
    .clk, .rst_n, .vld_i(in_valid), .dat_i(up_c), .vld_o(up_v), .dat_o(up_q)
  );

  // stage 2: align smaller mantissa, collapse lost bits into sticky
  logic [SH_W-1:0]  shamt;
  logic [ALN_W-1:0] wide;

  always_comb begin
    shamt = (up_q.diff > EXP_W'(2**SH_W - 1)) ? SH_W'(2**SH_W - 1) : up_q.diff[SH_W-1:0];
    wide  = {up_q.m_small, {EXT_W{1'b0}}} >> shamt;
    al_c.sign    = up_q.sign;
    al_c.eff_sub = up_q.eff_sub;
    al_c.exp_big = up_q.exp_big;
    al_c.m_big   = {up_q.m_big, 3'b000};
    al_c.m_small = {wide[ALN_W-1 -: EXT_W-1], |wide[ALN_W-EXT_W:0]};
  end

  fpadd_slice #(.W($bits(algn_t)), .DEPTH(ST_ALIGN)) u_sl_align (
    .clk, .rst_n, .vld_i(up_v), .dat_i(al_c), .vld_o(al_v), .dat_o(al_q)
  );

  // stage 3: fixed-point add or subtract
  always_comb begin
    sm_c.sign    = al_q.sign;
    sm_c.exp_big = al_q.exp_big;
    sm_c.sum     = al_q.eff_sub ? ({1'b0, al_q.m_big} - {1'b0, al_q.m_small})
                                : ({1'b0, al_q.m_big} + {1'b0, al_q.m_small});
  end

  AST_SUB_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (al_v && al_q.eff_sub) |-> (al_q.m_big >= al_q.m_small)); // R2

  fpadd_slice #(.W($bits(sum_t)), .DEPTH(ST_ADDSUB)) u_sl_addsub (
    .clk, .rst_n, .vld_i(al_v), .dat_i(sm_c), .vld_o(sm_v), .dat_o(sm_q)
  );

  // stage 4: leading-one search and normalisation
  fpadd_norm u_norm (
    .clk, .rst_n, .vld_i(sm_v), .sum_i(sm_q), .nrm_o(nm_c)
  );
  fpadd_slice #(.W($bits(norm_t)), .DEPTH(ST_NORM)) u_sl_norm (
    .clk, .rst_n, .vld_i(sm_v), .dat_i(nm_c), .vld_o(nm_v), .dat_o(nm_q)
  );

  // stage 5: round to nearest even, renormalise, overflow
  fpadd_round u_round (
    .clk, .rst_n, .vld_i(nm_v), .nrm_i(nm_q), .res_o(rd_c)
  );
  fpadd_slice #(.W(WORD_W), .DEPTH(ST_ROUND)) u_sl_round (
    .clk, .rst_n, .vld_i(nm_v), .dat_i(rd_c), .vld_o(out_valid), .dat_o(out_res)
  );

  // occupancy tracker for the latency check
  logic [CNT_W-1:0] in_flight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_flight <= '0;
    else        in_flight <= in_flight + CNT_W'(in_valid) - CNT_W'(out_valid);
  end

  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight <= CNT_W'(LATENCY)); // R9

  AST_NO_GHOST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |-> (in_flight != '0)); // R9

endmodule

// File: tb/fpadd_pipe_tb_top.sv
`timescale 1ns/1ps
module fpadd_pipe_tb_top;

  localparam int LAT_A = 6;
  localparam int LAT_B = 9;
  localparam int HMAX  = 4096;
  localparam int NRAND = 2600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sub = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        ov_a, ov_b;
  logic [31:0] or_a, or_b;

  always #4 clk = ~clk;

  fpadd_pipe dut_i (
    .clk, .rst_n, .in_valid, .in_sub, .in_a, .in_b, .out_valid(ov_a), .out_res(or_a)
  );

  fpadd_pipe #(.ST_UNPACK(0), .ST_ALIGN(3), .ST_ADDSUB(2), .ST_NORM(0), .ST_ROUND(4)) dut_deep_i (
    .clk, .rst_n, .in_valid, .in_sub, .in_a, .in_b, .out_valid(ov_b), .out_res(or_b)
  );

  int n_chk = 0;
  int n_fail = 0;
  int step_i = 0;
  bit done = 1'b0;

  logic        hv [HMAX];
  logic [31:0] hr [HMAX];
  string       ht [HMAX];

  // exact reference: wide integer sum, then round to nearest even
  function automatic logic [31:0] ref_add(input logic [31:0] a, input logic [31:0] b, input logic sub);
    logic [299:0] va, vb, m, rem, half;
    logic [24:0]  mr;
    logic         sa, sb, s;
    int           ea, eb, p, e;
    sa = a[31];
    sb = b[31] ^ sub;
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    va = '0;
    vb = '0;
    if (ea != 0) va = 300'({1'b1, a[22:0]}) << ea;
    if (eb != 0) vb = 300'({1'b1, b[22:0]}) << eb;
    if (sa == sb)      begin m = va + vb; s = sa; end
    else if (va >= vb) begin m = va - vb; s = sa; end
    else               begin m = vb - va; s = sb; end
    if (m == '0) return 32'h0000_0000;
    p = 0;
    for (int i = 0; i < 300; i++) if (m[i]) p = i;
    e = p - 23;
    if (e < 1) return {s, 31'b0};
    mr   = {1'b0, 24'(m >> e)};
    rem  = m & ((300'(1) << e) - 300'(1));
    half = 300'(1) << (e - 1);
    if (rem > half || (rem == half && mr[0])) mr = mr + 25'd1;
    if (mr[24]) begin
      mr = mr >> 1;
      e  = e + 1;
    end
    if (e >= 255) return {s, 8'hFF, 23'b0};
    return {s, 8'(e), mr[22:0]};
  endfunction

  function automatic logic [31:0] rnd_fp(input int e_lo, input int e_hi);
    int e;
    e = e_lo + int'($urandom % 32'(e_hi - e_lo + 1));
    return {1'($urandom), 8'(e), 23'($urandom)};
  endfunction

  task automatic check_port(input string who, input int lat, input logic v, input logic [31:0] r);
    int   idx;
    logic ev;
    idx = step_i - lat;
    ev  = (idx >= 0) ? hv[idx] : 1'b0;
    n_chk++;
    if (v !== ev) begin
      n_fail++;
      $display("FAIL R9 %s out_valid at step %0d: actual %0b expected %0b", who, step_i, v, ev);
    end else if (ev && r !== hr[idx]) begin
      n_fail++;
      $display("FAIL %s %s result for step %0d: actual %08h expected %08h", ht[idx], who, idx, r, hr[idx]);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b, input logic sub,
                      input logic use_lit, input logic [31:0] lit, input string tag);
    @(negedge clk);
    check_port("base", LAT_A, ov_a, or_a);
    check_port("deep", LAT_B, ov_b, or_b);
    in_valid = v;
    in_a     = a;
    in_b     = b;
    in_sub   = sub;
    hv[step_i] = v;
    hr[step_i] = use_lit ? lit : ref_add(a, b, sub);
    ht[step_i] = tag;
    step_i++;
  endtask

  task automatic dir(input logic [31:0] a, input logic [31:0] b, input logic sub,
                     input logic [31:0] lit, input string tag);
    step(1'b1, a, b, sub, 1'b1, lit, tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0C4B));
    #1 rst_n = 1'b0;
    // R10: valid held high during reset must not appear at the output
    in_valid = 1'b1;
    in_a = 32'h3F80_0000;
    in_b = 32'h3F80_0000;
    repeat (4) begin
      @(negedge clk);
      n_chk++;
      if (ov_a !== 1'b0 || ov_b !== 1'b0) begin
        n_fail++;
        $display("FAIL R10 out_valid in reset: actual %0b/%0b expected 0/0", ov_a, ov_b);
      end
    end
    in_valid = 1'b0;
    rst_n = 1'b1;

    // R1 same-sign addition
    dir(32'h3F80_0000, 32'h3F80_0000, 1'b0, 32'h4000_0000, "R1");
    dir(32'h3FC0_0000, 32'h4010_0000, 1'b0, 32'h4070_0000, "R1");
    // R2 subtract select
    dir(32'h3F80_0000, 32'h4000_0000, 1'b1, 32'hBF80_0000, "R2");
    dir(32'h40A0_0000, 32'h4040_0000, 1'b1, 32'h4000_0000, "R2");
    dir(32'h4000_0000, 32'hC000_0000, 1'b1, 32'h4080_0000, "R2");
    // R3 large exponent gaps
    dir(32'h3F80_0000, 32'h2F80_0000, 1'b0, 32'h3F80_0000, "R3");
    dir(32'h4B00_0000, 32'h3F00_0000, 1'b0, 32'h4B00_0000, "R3");
    // R4 cancellation and exact zero
    dir(32'h3F80_0001, 32'h3F80_0000, 1'b1, 32'h3400_0000, "R4");
    dir(32'h3F80_0000, 32'h3F80_0000, 1'b1, 32'h0000_0000, "R4");
    dir(32'hBF80_0000, 32'hBF80_0000, 1'b1, 32'h0000_0000, "R4");
    dir(32'h3F80_0000, 32'hBF80_0000, 1'b0, 32'h0000_0000, "R4");
    // R5 ties to even and above-half
    dir(32'h3F80_0000, 32'h3380_0000, 1'b0, 32'h3F80_0000, "R5");
    dir(32'h3F80_0001, 32'h3380_0000, 1'b0, 32'h3F80_0002, "R5");
    dir(32'h3F80_0000, 32'h33C0_0000, 1'b0, 32'h3F80_0001, "R5");
    // R6 rounding carry
    dir(32'h3FFF_FFFF, 32'h3380_0000, 1'b0, 32'h4000_0000, "R6");
    // R7 overflow to signed infinity
    dir(32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, 32'h7F80_0000, "R7");
    dir(32'hFF7F_FFFF, 32'hFF7F_FFFF, 1'b0, 32'hFF80_0000, "R7");
    dir(32'h7F7F_FFFF, 32'h7300_0000, 1'b0, 32'h7F80_0000, "R7");
    // R8 zero-exponent inputs and flushed tiny results
    dir(32'h0000_0001, 32'h3F80_0000, 1'b0, 32'h3F80_0000, "R8");
    dir(32'h0040_0000, 32'h0040_0000, 1'b0, 32'h0000_0000, "R8");
    dir(32'h0080_0001, 32'h0080_0000, 1'b1, 32'h0000_0000, "R8");
    dir(32'h8080_0001, 32'h8080_0000, 1'b1, 32'h8000_0000, "R8");
    dir(32'h0080_0000, 32'h8000_0001, 1'b0, 32'h0080_0000, "R8");
    // R9 idle gap between back-to-back bursts
    step(1'b0, '0, '0, 1'b0, 1'b0, '0, "R9");
    dir(32'h4040_0000, 32'h3F80_0000, 1'b0, 32'h4080_0000, "R9");
    step(1'b0, '0, '0, 1'b0, 1'b0, '0, "R9");
    step(1'b0, '0, '0, 1'b0, 1'b0, '0, "R9");

    for (int k = 0; k < NRAND; k++) begin
      logic [31:0] a, b;
      logic        sub, v;
      int          mode, e0;
      string       tag;
      mode = int'($urandom % 4);
      sub  = 1'($urandom);
      case (mode)
        0: begin
          e0 = 1 + int'($urandom % 250);
          a = rnd_fp(e0, e0 + 2);
          b = rnd_fp(e0, e0 + 2);
          tag = "R4";
        end
        1: begin
          e0 = 40 + int'($urandom % 150);
          a = rnd_fp(e0, e0);
          b = rnd_fp(e0 - 35, e0 - 3);
          tag = "R3";
        end
        2: begin
          a = rnd_fp(1, 254);
          b = rnd_fp(1, 254);
          tag = sub ? "R2" : "R1";
        end
        default: begin
          if ($urandom % 2 == 0) begin
            a = rnd_fp(250, 254);
            b = {a[31], rnd_fp(250, 254)};
            sub = 1'b0;
            tag = "R7";
          end else begin
            a = rnd_fp(1, 4);
            b = rnd_fp(1, 4);
            tag = "R8";
          end
        end
      endcase
      v = ($urandom % 8) != 0;
      if (!v) tag = "R9";
      step(v, a, b, sub, 1'b0, '0, tag);
    end

    repeat (12) step(1'b0, '0, '0, 1'b0, 1'b0, '0, "R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual run still busy, expected completion within 200000 cycles");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule